// File: doc/BRIEF.md
# Flash Identification Probe Controller

This controller reads the manufacturer and device identifiers from a parallel NOR flash device. It first clears the device with a reset command, then sends the three-write product-ID entry sequence and reads the two identifier locations. It then leaves ID mode and reads the same two locations a second time. Every bus write and read goes through a simple request/acknowledge port, the same kind that a program sequencer drives. Timed waits before and after the command groups come from a small timing setting. The setting can give one explicit delay for both phases, select no delay, select built-in defaults, or mark the configuration invalid. An invalid setting ends the probe at once.

The identifiers come back in extended form: when a byte reads as the continuation code 0x7F, one more byte is folded in. The block also reports an even-parity manufacturer byte. It raises a separate flag for each identifier that reads the same after exit as in ID mode, which usually means the device never entered ID mode and the bytes are ordinary array data. A match output compares both identifiers with expected values supplied on inputs. A probe is started with a single-cycle `start` pulse. Results hold from the `done` pulse until the next accepted start.

Top module: `flash_id_probe`

## Requirements
- R1: `cfg_timing` selects the delay source. Code 0 uses `cfg_delay` cycles for both the enter delay and the exit delay. Code 1 uses zero for both. Code 2 uses the parameters `DFLT_ENTER` and `DFLT_EXIT`.
- R2: `cfg_timing` code 3 ends the probe without any bus request. `done` and `aborted` are high in the cycle after the start cycle, and `bus_req` stays low whenever `busy` is low.
- R3: The write sequence is reset 0xF0, then 0xAA, 0x55 and 0x90, then exit 0xF0. The primary address is 0x5555 and the secondary address is 0x2AAA. With `cfg_shifted` set, the two addresses swap. 0x55 goes to the secondary address and every other command byte goes to the primary address.
- R4: With `cfg_long_reset` set, writes of 0xAA (primary address) and 0x55 (secondary address) come before each 0xF0. A gap of `GAP` cycles follows each of these two writes only when the exit delay is nonzero.
- R5: There are `enter` idle cycles between the start cycle and the first request, and after the 0x90 write. There are `exit` idle cycles after each 0xF0 write. A gap of `GAP` idle cycles follows the entry 0xAA and 0x55 writes only when the enter delay is nonzero. All other accesses follow one another with no idle cycle.
- R6: The manufacturer byte is read at offset 0 and the device byte at offset 1. With `cfg_shifted` set, these offsets become 0 and 2.
- R7: When a first identifier byte is 0x7F, one more byte is read, at 0x100 for the manufacturer or 0x101 for the device. The identifier then becomes {0x7F, extra byte}. Otherwise the identifier is the byte zero-extended to 16 bits.
- R8: `parity_err` is high after completion when the low byte of `mfr_id` has an even number of one bits.
- R9: After exit, both locations are read again under the same continuation rule. `mfr_as_array` and `dev_as_array` are high when the re-read identifier equals the ID-mode identifier.
- R10: `id_match` is high after a non-aborted completion exactly when `mfr_id` equals `exp_mfr` and `dev_id` equals `exp_dev`.
- R11: A request holds its address, direction and data stable until `bus_ack`. A `start` pulse while `busy` is high is ignored.
- R12: `done` is a one-cycle pulse in the cycle after the final acknowledge. The results then hold with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (sampled while idle) |
| cfg_timing | input | 2 | Timing select: 0 explicit, 1 none, 2 defaults, 3 invalid |
| cfg_delay | input | DLY_W | Explicit delay in cycles |
| cfg_long_reset | input | 1 | Prefix each 0xF0 with 0xAA/0x55 |
| cfg_shifted | input | 1 | Swap command addresses and shift ID offsets |
| exp_mfr | input | 16 | Expected manufacturer identifier |
| exp_dev | input | 16 | Expected device identifier |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access accepted; read data valid |
| bus_rdata | input | 8 | Read data |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Last probe ended on an invalid timing setting |
| mfr_id | output | 16 | Extended manufacturer identifier |
| dev_id | output | 16 | Extended device identifier |
| parity_err | output | 1 | Manufacturer low byte has even parity |
| mfr_as_array | output | 1 | Manufacturer ID equals its post-exit re-read |
| dev_as_array | output | 1 | Device ID equals its post-exit re-read |
| id_match | output | 1 | Both identifiers equal the expected inputs |

## Verification
The hardest case to reach is the interaction of the delay rules. The gaps inside the long-reset prefix depend on the exit delay, while the gaps inside the entry sequence depend on the enter delay. Both combine with continuation reads that appear only for particular data bytes. The bench therefore runs probes under each timing code, with and without the long prefix and shifted addressing. Its reference model supplies 0x7F bytes in either identifier, in ID mode and on re-read. The same model stalls the acknowledge for a varying number of cycles, so that held requests and the idle-cycle count before every access are checked together.

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int ADDR_W     = 16,
  parameter int DLY_W      = 24,
  parameter int DFLT_ENTER = 1000000,
  parameter int DFLT_EXIT  = 4000,
  parameter int GAP        = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_timing,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic              cfg_long_reset,
  input  logic              cfg_shifted,
  input  logic [15:0]       exp_mfr,
  input  logic [15:0]       exp_dev,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              aborted,
  output logic [15:0]       mfr_id,
  output logic [15:0]       dev_id,
  output logic              parity_err,
  output logic              mfr_as_array,
  output logic              dev_as_array,
  output logic              id_match
);

  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(16'h2AAA);
  localparam logic [ADDR_W-1:0] A_MEXT = ADDR_W'(16'h0100);
  localparam logic [ADDR_W-1:0] A_DEXT = ADDR_W'(16'h0101);
  localparam logic [7:0] C_UNLK1 = 8'hAA, C_UNLK2 = 8'h55, C_IDENT = 8'h90, C_RESET = 8'hF0;
  localparam logic [7:0] CONT = 8'h7F;

  typedef enum logic [4:0] {
    IDLE, RS_U1, RS_U2, RS_F0, EN_U1, EN_U2, EN_90,
    RD_M, RD_MX, RD_D, RD_DX, EX_U1, EX_U2, EX_F0,
    RR_M, RR_MX, RR_D, RR_DX
  } st_t;

  st_t              st, nxt;
  logic [DLY_W-1:0] tmr, post;
  logic [DLY_W-1:0] ent_q, ext_q, ent_c, ext_c;
  logic             long_q, shift_q, valid;
  logic [15:0]      mfr, dev, mfr_rr, dev_rr;
  logic [ADDR_W-1:0] prim, sec;
  logic [DLY_W-1:0] gap_x, gap_e;
  logic             acc, is7f;

  assign prim  = shift_q ? A_LO : A_HI;
  assign sec   = shift_q ? A_HI : A_LO;
  assign gap_x = (ext_q != '0) ? DLY_W'(GAP) : '0;
  assign gap_e = (ent_q != '0) ? DLY_W'(GAP) : '0;
  assign is7f  = (bus_rdata == CONT);

  assign ent_c = (cfg_timing == 2'd0) ? cfg_delay :
                 (cfg_timing == 2'd2) ? DLY_W'(DFLT_ENTER) : '0;
  assign ext_c = (cfg_timing == 2'd0) ? cfg_delay :
                 (cfg_timing == 2'd2) ? DLY_W'(DFLT_EXIT) : '0;

  assign busy    = (st != IDLE);
  assign bus_req = busy && (tmr == '0);
  assign acc     = bus_req && bus_ack;

  always_comb begin
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = 8'h00;
    nxt       = st;
    post      = '0;
    case (st)
      RS_U1: begin bus_we = 1'b1; bus_addr = prim; bus_wdata = C_UNLK1; nxt = RS_U2; post = gap_x; end
      RS_U2: begin bus_we = 1'b1; bus_addr = sec;  bus_wdata = C_UNLK2; nxt = RS_F0; post = gap_x; end
      RS_F0: begin bus_we = 1'b1; bus_addr = prim; bus_wdata = C_RESET; nxt = EN_U1; post = ext_q; end
      EN_U1: begin bus_we = 1'b1; bus_addr = prim; bus_wdata = C_UNLK1; nxt = EN_U2; post = gap_e; end
      EN_U2: begin bus_we = 1'b1; bus_addr = sec;  bus_wdata = C_UNLK2; nxt = EN_90; post = gap_e; end
      EN_90: begin bus_we = 1'b1; bus_addr = prim; bus_wdata = C_IDENT; nxt = RD_M;  post = ent_q; end
      RD_M:  begin bus_addr = '0;     nxt = is7f ? RD_MX : RD_D; end
      RD_MX: begin bus_addr = A_MEXT; nxt = RD_D; end
      RD_D:  begin bus_addr = shift_q ? ADDR_W'(2) : ADDR_W'(1);
                   nxt = is7f ? RD_DX : (long_q ? EX_U1 : EX_F0); end
      RD_DX: begin bus_addr = A_DEXT; nxt = long_q ? EX_U1 : EX_F0; end
      EX_U1: begin bus_we = 1'b1; bus_addr = prim; bus_wdata = C_UNLK1; nxt = EX_U2; post = gap_x; end
      EX_U2: begin bus_we = 1'b1; bus_addr = sec;  bus_wdata = C_UNLK2; nxt = EX_F0; post = gap_x; end
      EX_F0: begin bus_we = 1'b1; bus_addr = prim; bus_wdata = C_RESET; nxt = RR_M;  post = ext_q; end
      RR_M:  begin bus_addr = '0;     nxt = is7f ? RR_MX : RR_D; end
      RR_MX: begin bus_addr = A_MEXT; nxt = RR_D; end
      RR_D:  begin bus_addr = shift_q ? ADDR_W'(2) : ADDR_W'(1); nxt = is7f ? RR_DX : IDLE; end
      RR_DX: begin bus_addr = A_DEXT; nxt = IDLE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; tmr <= '0; ent_q <= '0; ext_q <= '0;
      long_q <= 1'b0; shift_q <= 1'b0; valid <= 1'b0;
      done <= 1'b0; aborted <= 1'b0;
      mfr <= '0; dev <= '0; mfr_rr <= '0; dev_rr <= '0;
    end else begin
      done <= 1'b0;
      if (st == IDLE) begin
        if (start) begin
          valid   <= 1'b0;
          ent_q   <= ent_c;
          ext_q   <= ext_c;
          long_q  <= cfg_long_reset;
          shift_q <= cfg_shifted;
          if (cfg_timing == 2'd3) begin
            aborted <= 1'b1;
            done    <= 1'b1;
          end else begin
            aborted <= 1'b0;
            tmr     <= ent_c;
            st      <= cfg_long_reset ? RS_U1 : RS_F0;
          end
        end
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else if (acc) begin
        st  <= nxt;
        tmr <= post;
        case (st)
          RD_M:  mfr    <= {8'h00, bus_rdata};
          RD_MX: mfr    <= {mfr[7:0], bus_rdata};
          RD_D:  dev    <= {8'h00, bus_rdata};
          RD_DX: dev    <= {dev[7:0], bus_rdata};
          RR_M:  mfr_rr <= {8'h00, bus_rdata};
          RR_MX: mfr_rr <= {mfr_rr[7:0], bus_rdata};
          RR_D:  dev_rr <= {8'h00, bus_rdata};
          RR_DX: dev_rr <= {dev_rr[7:0], bus_rdata};
          default: ;
        endcase
        if (nxt == IDLE) begin
          done  <= 1'b1;
          valid <= 1'b1;
        end
      end
    end
  end

  assign mfr_id       = mfr;
  assign dev_id       = dev;
  assign parity_err   = valid && !(^mfr[7:0]);
  assign mfr_as_array = valid && (mfr == mfr_rr);
  assign dev_as_array = valid && (dev == dev_rr);
  assign id_match     = valid && (mfr == exp_mfr) && (dev == exp_dev);

endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_ack,
  input logic              busy,
  input logic              done,
  input logic              aborted,
  input logic              id_match
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req); // R2

  AST_ABORT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> !bus_req); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_WRITE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> (bus_wdata == 8'hAA || bus_wdata == 8'h55 ||
                           bus_wdata == 8'h90 || bus_wdata == 8'hF0)); // R3

  AST_MATCH_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    id_match |-> !busy && !aborted); // R10

endmodule

bind flash_id_probe flash_id_probe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .busy(busy), .done(done), .aborted(aborted), .id_match(id_match)
);

// File: tb/test_flash_id_probe.sv
module test_flash_id_probe;
  localparam int DLY_W = 16, DE = 20, DX = 7, GP = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] cfg_timing = 2'd0;
  logic [DLY_W-1:0] cfg_delay = '0;
  logic cfg_long_reset = 1'b0, cfg_shifted = 1'b0;
  logic [15:0] exp_mfr = '0, exp_dev = '0;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = 8'h00;
  logic busy, done, aborted, parity_err, mfr_as_array, dev_as_array, id_match;
  logic [15:0] mfr_id, dev_id;

  always #5 clk = ~clk;

  flash_id_probe #(.ADDR_W(16), .DLY_W(DLY_W), .DFLT_ENTER(DE), .DFLT_EXIT(DX), .GAP(GP)) i_flash_id_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_timing(cfg_timing), .cfg_delay(cfg_delay),
    .cfg_long_reset(cfg_long_reset), .cfg_shifted(cfg_shifted), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .done(done), .aborted(aborted),
    .mfr_id(mfr_id), .dev_id(dev_id), .parity_err(parity_err), .mfr_as_array(mfr_as_array),
    .dev_as_array(dev_as_array), .id_match(id_match));

  typedef struct { bit we; logic [15:0] addr; logic [7:0] data; int pre; } acc_t;
  acc_t q[$];
  int n_chk = 0, n_fail = 0, npre = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic add(input bit we, input logic [15:0] a, input logic [7:0] d);
    acc_t e;
    e.we = we; e.addr = a; e.data = d; e.pre = npre;
    q.push_back(e);
    npre = 0;
  endtask

  task automatic add_id(input logic [15:0] a, input logic [15:0] ext, input logic [7:0] b0, input logic [7:0] b1);
    add(0, a, b0);
    if (b0 == 8'h7F) add(0, ext, b1);
  endtask

  function automatic logic [15:0] ext_id(input logic [7:0] b0, input logic [7:0] b1);
    return (b0 == 8'h7F) ? {b0, b1} : {8'h00, b0};
  endfunction

  task automatic probe(input string name, input logic [1:0] tm, input int dly, input bit lng, input bit sh,
                       input logic [7:0] m0, m1, d0, d1, r0, r1, r2, r3,
                       input logic [15:0] em, ed, input int inject);
    int ent, ext, gx, ge, cyc, stall, idle;
    logic [15:0] P, S, xm, xd, xrm, xrd;
    bit waiting;
    ent = (tm == 2'd0) ? dly : (tm == 2'd2) ? DE : 0;
    ext = (tm == 2'd0) ? dly : (tm == 2'd2) ? DX : 0;
    gx = (ext != 0) ? GP : 0;
    ge = (ent != 0) ? GP : 0;
    P = sh ? 16'h2AAA : 16'h5555;
    S = sh ? 16'h5555 : 16'h2AAA;
    q.delete();
    if (tm != 2'd3) begin
      npre = ent;
      if (lng) begin add(1, P, 8'hAA); npre = gx; add(1, S, 8'h55); npre = gx; end
      add(1, P, 8'hF0); npre = ext;
      add(1, P, 8'hAA); npre = ge; add(1, S, 8'h55); npre = ge; add(1, P, 8'h90); npre = ent;
      add_id(16'h0000, 16'h0100, m0, m1);
      add_id(sh ? 16'h0002 : 16'h0001, 16'h0101, d0, d1);
      if (lng) begin add(1, P, 8'hAA); npre = gx; add(1, S, 8'h55); npre = gx; end
      add(1, P, 8'hF0); npre = ext;
      add_id(16'h0000, 16'h0100, r0, r1);
      add_id(sh ? 16'h0002 : 16'h0001, 16'h0101, r2, r3);
    end
    xm = ext_id(m0, m1); xd = ext_id(d0, d1); xrm = ext_id(r0, r1); xrd = ext_id(r2, r3);
    @(negedge clk);
    cfg_timing = tm; cfg_delay = DLY_W'(dly); cfg_long_reset = lng; cfg_shifted = sh;
    exp_mfr = em; exp_dev = ed; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idle = (q.size() > 0) ? q[0].pre : 0;
    stall = 1; cyc = 0; waiting = 1;
    while (waiting) begin
      if (cyc == inject) begin start = 1'b1; cfg_timing = 2'd3; cfg_long_reset = ~lng; end
      else if (cyc == inject + 1) begin start = 1'b0; cfg_timing = tm; cfg_long_reset = lng; end
      if (q.size() == 0) begin
        chk(done === 1'b1, {name, " R12 done pulse"}, done, 1);
        waiting = 0;
      end else begin
        if (done !== 1'b0) chk(0, {name, " R12 early done"}, done, 0);
        if (idle > 0) begin
          if (bus_req !== 1'b0) chk(0, {name, " R5 idle cycle"}, bus_req, 0);
          idle--;
        end else begin
          chk(bus_req === 1'b1 && bus_we === q[0].we && bus_addr === q[0].addr &&
              (!q[0].we || bus_wdata === q[0].data),
              {name, " R3 R4 R6 R7 access"}, {bus_req, bus_we, 6'd0, bus_wdata, bus_addr},
              {1'b1, q[0].we, 6'd0, q[0].we ? q[0].data : bus_wdata, q[0].addr});
          if (stall > 0) stall--;
          else begin
            bus_ack = 1'b1;
            bus_rdata = q[0].data;
            void'(q.pop_front());
            if (q.size() > 0) idle = q[0].pre;
            stall = q.size() % 3;
          end
        end
      end
      @(negedge clk);
      bus_ack = 1'b0;
      cyc++;
    end
    chk(done === 1'b0 && busy === 1'b0, {name, " R12 rest after done"}, {done, busy}, 0);
    chk(aborted === (tm == 2'd3), {name, " R2 abort flag"}, aborted, tm == 2'd3);
    if (tm != 2'd3) begin
      chk(mfr_id === xm, {name, " R7 mfr_id"}, mfr_id, xm);
      chk(dev_id === xd, {name, " R7 dev_id"}, dev_id, xd);
      chk(parity_err === !(^xm[7:0]), {name, " R8 parity"}, parity_err, !(^xm[7:0]));
      chk(mfr_as_array === (xm == xrm), {name, " R9 mfr array"}, mfr_as_array, xm == xrm);
      chk(dev_as_array === (xd == xrd), {name, " R9 dev array"}, dev_as_array, xd == xrd);
      chk(id_match === (xm == em && xd == ed), {name, " R10 match"}, id_match, xm == em && xd == ed);
    end else begin
      chk(id_match === 1'b0, {name, " R10 no match on abort"}, id_match, 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 0 && done === 0 && bus_req === 0 && id_match === 0 && aborted === 0,
        "R12 reset state", {busy, done, bus_req, id_match, aborted}, 0);
    // R1 explicit delay, R11 start ignored mid-probe
    probe("explicit", 2'd0, 4, 0, 0, 8'hBF, 8'h00, 8'hB6, 8'h00, 8'h12, 8'h00, 8'h34, 8'h00,
          16'h00BF, 16'h00B6, 9);
    // R1 zero timing, R4 no gaps, R6 shifted, R7 continuation both, R8 even parity
    probe("zero_long_shift", 2'd1, 0, 1, 1, 8'h7F, 8'h03, 8'h7F, 8'h41, 8'hFF, 8'h00, 8'h7F, 8'h41,
          16'h7F03, 16'h7F41, -5);
    // R1 defaults, R4 gaps, R9 array look-alike
    probe("default_long", 2'd2, 0, 1, 0, 8'h01, 8'h00, 8'h7F, 8'h22, 8'h01, 8'h00, 8'h7F, 8'h22,
          16'h0001, 16'h0000, -5);
    // R2 abort
    probe("abort", 2'd3, 9, 1, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
          16'h0000, 16'h0000, -5);
    // R5 explicit zero delay with long prefix, R10 mismatch
    probe("explicit0", 2'd0, 0, 1, 1, 8'h20, 8'h00, 8'h7F, 8'h7F, 8'h21, 8'h00, 8'h7F, 8'h7E,
          16'h0020, 16'h7F00, -5);
    // R1 explicit nonzero with shift only
    probe("explicit_shift", 2'd0, 2, 0, 1, 8'h7F, 8'hC2, 8'h55, 8'h00, 8'h7F, 8'hC2, 8'h56, 8'h00,
          16'h7FC2, 16'h0055, -5);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule